// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port that runs as a slave. An external master supplies the shift clock, and the block never generates a clock of its own. The host writes a data word into a one-deep holding stage. When the shift stage is idle, the word moves into it and goes out on a single data line, least significant bit first. A new bit is presented on each data-drive edge of the external clock. A clock-polarity input selects whether that edge is the rising or the falling one.

The port is double-buffered. The host can queue a second word while the first is still shifting, and the queued word moves across without help when the last bit of the first word has gone out. A buffer-empty flag tracks the holding stage. Combined with an interrupt enable, it gives an interrupt request, and that request doubles as a wake request while the low-power input is high. The shift clock comes from outside, so shifting continues in low-power mode. A queued second word therefore raises the wake request exactly when it enters the shift stage. An optional 9-bit mode appends a ninth bit, which is taken from a separate input when the word is written.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `buf_empty`=1, `shift_empty`=1, `ser_out`=1, `irq`=0 and `wake`=0.
- R2: The port is active only when `port_en`=1, `sync_mode`=1, `master_sel`=0, `tx_en`=1 and `rx_en`=0. While it is inactive, writes are ignored, both stages are emptied and `ser_out` stays at the idle level 1.
- R3: Suppose the port is active and both stages are empty. A word written with `wr_en`=1 enters the shift stage on the second rising system clock edge after the write edge. At that point `shift_empty` drops to 0 and `ser_out` carries bit 0 of the word.
- R4: Bits leave least significant bit first. Each later bit appears after one data-drive edge of `sclk_in`, seen through a two-flop synchronizer. `clk_pol`=0 selects the rising edge as the drive edge and `clk_pol`=1 selects the falling edge. Edges of the other direction do not move the data.
- R5: With `nine_bit`=1, the value of `bit9_in` sampled at the write is sent as a ninth bit after data bit 7. With `nine_bit`=0, exactly 8 bits are sent.
- R6: After the final drive edge of a word, with nothing queued, `shift_empty` returns to 1 and `ser_out` returns to 1.
- R7: A word written while the shift stage is busy waits in the holding stage, and `buf_empty` stays 0 for the whole wait, in low-power mode as well. The word enters the shift stage as soon as the previous word's last bit is done, and only then does `buf_empty` return to 1.
- R8: A write made while the holding stage is full is ignored, and the queued word is sent unchanged.
- R9: `irq` equals `buf_empty` AND `irq_en`, and `wake` equals `irq` AND `low_power`.
- R10: `low_power` has no effect on shifting. Words are shifted out identically with it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External shift clock from the master (asynchronous) |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| master_sel | input | 1 | Clock source select, must be 0 for slave operation |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | OR of the receive enables, must be 0 |
| nine_bit | input | 1 | 1 selects 9-bit words |
| bit9_in | input | 1 | Ninth data bit, captured with the write |
| clk_pol | input | 1 | 0: drive on rising edge, 1: drive on falling edge |
| wr_en | input | 1 | Host write strobe for the holding stage |
| wr_data | input | 8 | Host data word |
| low_power | input | 1 | Core low-power indication |
| irq_en | input | 1 | Transmit interrupt enable |
| ser_out | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding stage empty flag |
| shift_empty | output | 1 | Shift stage holds no bits to send |
| irq | output | 1 | Transmit interrupt request |
| wake | output | 1 | Wake request while in low-power mode |

## Verification
The bench queues a second word in low-power mode and watches `buf_empty`, `irq` and `wake` during the wait. A design that raised the flag when the first word was accepted would wake the core one word too early. While the queue is full, the bench writes a third word and then checks the serial stream of the second. A design that overwrote the holding stage would send the wrong bits. Words are sent with both clock polarities and both word lengths. This catches shifting on the wrong edge, a missing ninth bit, or a ninth bit sent in 8-bit mode. A write made while `rx_en` is set must leave both stages empty, which exposes a gating term missing from the enable logic.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    localparam int SSX_DATA_W  = 8;
    localparam int SSX_FRAME_W = SSX_DATA_W + 1;
    localparam int SSX_CNT_W   = $clog2(SSX_FRAME_W + 1);
    localparam logic SSX_IDLE_LVL = 1'b1;

    typedef enum logic {
        DRIVE_RISE = 1'b0,
        DRIVE_FALL = 1'b1
    } ssx_edge_e;

    typedef struct packed {
        logic                   nine;
        logic [SSX_FRAME_W-1:0] bits;
    } ssx_word_t;

    function automatic logic [SSX_CNT_W-1:0] ssx_len(input logic nine);
        return nine ? SSX_CNT_W'(SSX_FRAME_W) : SSX_CNT_W'(SSX_DATA_W);
    endfunction
endpackage

// File: rtl/ssx_edge_sync.sv
module ssx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/ssx_holding.sv
module ssx_holding
    import ssx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      wr,
    input  ssx_word_t din,
    input  logic      pop,
    output logic      full,
    output ssx_word_t word
);
    logic      full_q;
    ssx_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full_q <= 1'b0;
            word_q <= '0;
        end else if (wr && !full_q) begin
            word_q <= din;
            full_q <= 1'b1;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    assign full = full_q;
    assign word = word_q;

    // R8
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst || clear)
        (full_q && wr) |=> (word_q == $past(word_q)));
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter
    import ssx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      load,
    input  ssx_word_t word,
    input  logic      tick,
    output logic      ser,
    output logic      idle
);
    logic [SSX_FRAME_W-1:0] sr_q;
    logic [SSX_CNT_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sr_q   <= word.bits;
            left_q <= ssx_len(word.nine);
        end else if (tick && left_q != '0) begin
            sr_q   <= sr_q >> 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign idle = (left_q == '0);
    assign ser  = idle ? SSX_IDLE_LVL : sr_q[0];

    // R6
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        left_q <= SSX_CNT_W'(SSX_FRAME_W));
    // R3
    load_busy_chk: assert property (@(posedge clk) disable iff (rst || clear)
        load |=> !idle);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
    import ssx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_in,
    input  logic                  port_en,
    input  logic                  sync_mode,
    input  logic                  master_sel,
    input  logic                  tx_en,
    input  logic                  rx_en,
    input  logic                  nine_bit,
    input  logic                  bit9_in,
    input  logic                  clk_pol,
    input  logic                  wr_en,
    input  logic [SSX_DATA_W-1:0] wr_data,
    input  logic                  low_power,
    input  logic                  irq_en,
    output logic                  ser_out,
    output logic                  buf_empty,
    output logic                  shift_empty,
    output logic                  irq,
    output logic                  wake
);
    logic      active, rise, fall, tick, hold_full, shift_idle, pop;
    ssx_word_t in_word, held_word;
    ssx_edge_e drive_edge;

    assign active     = port_en & sync_mode & ~master_sel & tx_en & ~rx_en;
    assign drive_edge = ssx_edge_e'(clk_pol);
    assign in_word    = '{nine: nine_bit, bits: {bit9_in, wr_data}};

    ssx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(sclk_in), .rise(rise), .fall(fall)
    );

    assign tick = active & ((drive_edge == DRIVE_FALL) ? fall : rise);

    ssx_holding u_hold (
        .clk(clk), .rst(rst), .clear(~active), .wr(wr_en & active),
        .din(in_word), .pop(pop), .full(hold_full), .word(held_word)
    );

    assign pop = active & hold_full & shift_idle;

    ssx_shifter u_shift (
        .clk(clk), .rst(rst), .clear(~active), .load(pop), .word(held_word),
        .tick(tick), .ser(ser_out), .idle(shift_idle)
    );

    assign buf_empty   = ~hold_full;
    assign shift_empty = shift_idle;
    assign irq         = buf_empty & irq_en;
    assign wake        = irq & low_power;

    // R7
    pending_wait_chk: assert property (@(posedge clk) disable iff (rst || !active)
        (hold_full && !shift_idle) |=> hold_full);
    // R7
    flag_on_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(buf_empty) && $past(active)) |-> $past(pop));
endmodule

// File: tb/sync_slave_tx_test.sv
module sync_slave_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int EDGE_WAIT  = 6;

    logic clk = 1'b0;
    logic rst, sclk_in, port_en, sync_mode, master_sel, tx_en, rx_en;
    logic nine_bit, bit9_in, clk_pol, wr_en, low_power, irq_en;
    logic [7:0] wr_data;
    logic ser_out, buf_empty, shift_empty, irq, wake;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_slave_tx uut (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .port_en(port_en),
        .sync_mode(sync_mode), .master_sel(master_sel), .tx_en(tx_en),
        .rx_en(rx_en), .nine_bit(nine_bit), .bit9_in(bit9_in),
        .clk_pol(clk_pol), .wr_en(wr_en), .wr_data(wr_data),
        .low_power(low_power), .irq_en(irq_en), .ser_out(ser_out),
        .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq), .wake(wake)
    );

    // {pol, nine, bit9, data[7:0], expected bit count[3:0]}
    localparam int NVEC = 6;
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 4'd8},
        {1'b0, 1'b0, 1'b1, 8'h3C, 4'd8},
        {1'b1, 1'b0, 1'b0, 8'h81, 4'd8},
        {1'b0, 1'b1, 1'b1, 8'h00, 4'd9},
        {1'b1, 1'b1, 1'b0, 8'hFF, 4'd9},
        {1'b1, 1'b1, 1'b1, 8'h6E, 4'd9}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_cycle(input logic pol);
        sclk_in = ~pol; wait_n(EDGE_WAIT);
        sclk_in = pol;  wait_n(EDGE_WAIT);
    endtask

    task automatic write_word(input logic [7:0] d, input logic nb, input logic b9);
        wr_data = d; nine_bit = nb; bit9_in = b9; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic collect(input logic pol, input int len, output logic [8:0] got);
        got = '0;
        for (int i = 0; i < len; i++) begin
            got[i] = ser_out;
            ext_cycle(pol);
        end
    endtask

    task automatic set_pol(input logic pol);
        clk_pol = pol; sclk_in = pol; wait_n(EDGE_WAIT);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0] got;
        logic [8:0] expv;
        rst = 1'b1; sclk_in = 1'b0; port_en = 1'b1; sync_mode = 1'b1;
        master_sel = 1'b0; tx_en = 1'b1; rx_en = 1'b0; nine_bit = 1'b0;
        bit9_in = 1'b0; clk_pol = 1'b0; wr_en = 1'b0; wr_data = '0;
        low_power = 1'b0; irq_en = 1'b0;
        wait_n(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {11'd0, buf_empty, shift_empty, ser_out, irq, wake}, 16'b11100);

        // R4 R5 R6: table walk
        for (int v = 0; v < NVEC; v++) begin
            logic pol, nb, b9;
            logic [7:0] d;
            int len;
            {pol, nb, b9, d} = VEC[v][14:4];
            len = int'(VEC[v][3:0]);
            set_pol(pol);
            write_word(d, nb, b9);
            // R3: word in shift stage, bit 0 on the line
            check("R3", {14'd0, shift_empty, ser_out}, {14'd0, 1'b0, d[0]});
            collect(pol, len, got);
            expv = nb ? {b9, d} : {1'b0, d};
            check(nb ? "R5" : "R4", {7'd0, got}, {7'd0, expv});
            // R6: idle after last drive edge
            check("R6", {14'd0, shift_empty, ser_out}, 16'b11);
        end

        // R4: opposite edge does not move data (pol 0, falling only)
        set_pol(1'b0);
        write_word(8'h02, 1'b0, 1'b0);
        sclk_in = 1'b1; wait_n(EDGE_WAIT);
        check("R4", {15'd0, ser_out}, 16'd1);
        sclk_in = 1'b0; wait_n(EDGE_WAIT);
        check("R4", {15'd0, ser_out}, 16'd1);
        collect(1'b0, 7, got);
        check("R4", {7'd0, got}, {7'd0, 9'h001});

        // R7 R8 R9 R10: double buffer in low power
        low_power = 1'b1; irq_en = 1'b1;
        write_word(8'hC3, 1'b0, 1'b0);
        write_word(8'h5A, 1'b0, 1'b0);
        check("R7", {13'd0, buf_empty, irq, wake}, 16'b000);
        write_word(8'hFF, 1'b0, 1'b0);
        collect(1'b0, 7, got);
        check("R7", {15'd0, buf_empty}, 16'd0);
        ext_cycle(1'b0);
        check("R9", {13'd0, buf_empty, irq, wake}, 16'b111);
        check("R7", {15'd0, shift_empty}, 16'd0);
        collect(1'b0, 8, got);
        check("R8", {7'd0, got}, {7'd0, 9'h05A});
        check("R10", {14'd0, shift_empty, ser_out}, 16'b11);
        irq_en = 1'b0; @(negedge clk);
        check("R9", {13'd0, buf_empty, irq, wake}, 16'b100);
        irq_en = 1'b1; low_power = 1'b0; @(negedge clk);
        check("R9", {13'd0, buf_empty, irq, wake}, 16'b110);

        // R2: receive enabled blocks transmit
        rx_en = 1'b1;
        write_word(8'h00, 1'b0, 1'b0);
        wait_n(2);
        check("R2", {13'd0, buf_empty, shift_empty, ser_out}, 16'b111);
        rx_en = 1'b0;
        // R2: dropping tx_en mid-word empties both stages
        write_word(8'h00, 1'b0, 1'b0);
        write_word(8'h11, 1'b0, 1'b0);
        tx_en = 1'b0; wait_n(2);
        check("R2", {13'd0, buf_empty, shift_empty, ser_out}, 16'b111);
        tx_en = 1'b1; master_sel = 1'b1;
        write_word(8'h00, 1'b0, 1'b0);
        check("R2", {14'd0, shift_empty, ser_out}, 16'b11);
        master_sel = 1'b0;

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule